// File: doc/BRIEF.md
# ECC Error Reporting and Capture Unit

This block sits beside an SRAM controller and a flash controller and watches the ECC event pulses they produce. Each memory signals a corrected single-bit event and a non-correctable multi-bit event. Both share one payload per memory: the faulting address, the bus attributes, the data word and the number of the requesting bus master. The SRAM payload also carries the ECC syndrome. A byte-wide configuration register holds four enables, one for each pairing of error class and memory.

When an event's enable is set, it sets a sticky status flag and raises the interrupt request. If that memory's capture registers are free, the payload is also copied into them. Software reads the configuration, the status and the captured details over a small byte-addressed register bus, and clears flags by writing ones. A non-correctable event always drives that memory's error-response output, so the faulting access is terminated whether or not reporting is enabled. This covers failures that the requesting master would never see, such as discarded speculative fetches and buffered writes.

Top module: `eccCapture`

## Requirements
- R1: The configuration register sits at byte offset 0x43 and resets to 0x00. Its bit 5 enables SRAM single-bit reporting, bit 4 enables flash single-bit reporting, bit 1 enables SRAM non-correctable reporting and bit 0 enables flash non-correctable reporting (bit 0 is the LSB). Bits 7, 6, 3 and 2 ignore writes and read as 0.
- R2: An event whose enable bit is clear sets no flag, raises no interrupt and loads no capture register.
- R3: An enabled SRAM single-bit event sets status bit 5 at the rising edge where the pulse is sampled.
- R4: An enabled flash single-bit event sets status bit 4 at that edge.
- R5: An enabled SRAM non-correctable event sets status bit 1 at that edge.
- R6: An enabled flash non-correctable event sets status bit 0 at that edge.
- R7: The status register sits at byte offset 0x42 and resets to 0x00. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. `irq` is high exactly while any status bit is set.
- R8: An enabled SRAM event whose capture registers are free loads them at that edge:
  - address at 0x00
  - syndrome at 0x04
  - master number at 0x08
  - attributes at 0x0C
  - data at 0x10

  Each value is zero-extended to 32 bits.
- R9: An enabled flash event whose capture registers are free loads them at that edge:
  - address at 0x20
  - master number at 0x24
  - attributes at 0x28
  - data at 0x2C

  Flash has no syndrome capture.
- R10: While any status flag of a memory is set, that memory's capture registers keep their contents. Once software has cleared those flags, the next enabled event reloads them.
- R11: `sramErrResp` and `flashErrResp` are high in every cycle in which that memory's non-correctable pulse is high, whatever the enables say.
- R12: When enabled single-bit and non-correctable events of one memory arrive in the same cycle, both flags are set and the shared payload is captured once. When an event sets a flag in the same cycle that software clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sramSingle | input | 1 | SRAM corrected single-bit event pulse |
| sramMulti | input | 1 | SRAM non-correctable event pulse |
| sramAddr | input | 32 | SRAM faulting address |
| sramAttr | input | 8 | SRAM access attributes |
| sramData | input | 32 | SRAM access data |
| sramMaster | input | 4 | SRAM requesting master number |
| sramSyndrome | input | 8 | SRAM ECC syndrome |
| sramErrResp | output | 1 | Terminate current SRAM access with error |
| flashSingle | input | 1 | Flash corrected single-bit event pulse |
| flashMulti | input | 1 | Flash non-correctable event pulse |
| flashAddr | input | 32 | Flash faulting address |
| flashAttr | input | 8 | Flash access attributes |
| flashData | input | 32 | Flash access data |
| flashMaster | input | 4 | Flash requesting master number |
| flashErrResp | output | 1 | Terminate current flash access with error |
| regSel | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 8 | Register write byte |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| irq | output | 1 | ECC interrupt request |

## Verification
The hardest condition to reach from the ports is the capture lock. It only shows when a second enabled event arrives while a flag of the same memory is still set. The bench therefore fires two SRAM single-bit events with different payloads back to back and reads the captured address before any clear. It then clears the flag and fires a third event to show that the registers reload. It also drives single-bit and non-correctable pulses together, and drives non-correctable pulses with reporting disabled, so that the error response can be seen apart from the flags.

// File: rtl/eccCapturePkg.sv
package eccCapturePkg;

  typedef struct packed {
    logic loadSram;
    logic loadFlash;
  } capStrobe_t;

  localparam int unsigned BitSramSingle  = 5;
  localparam int unsigned BitFlashSingle = 4;
  localparam int unsigned BitSramMulti   = 1;
  localparam int unsigned BitFlashMulti  = 0;
  localparam logic [7:0]  FlagMask       = 8'h33;

  localparam logic [7:0] OffCfg        = 8'h43;
  localparam logic [7:0] OffStatus     = 8'h42;
  localparam logic [7:0] OffSramAddr   = 8'h00;
  localparam logic [7:0] OffSramSyn    = 8'h04;
  localparam logic [7:0] OffSramMaster = 8'h08;
  localparam logic [7:0] OffSramAttr   = 8'h0C;
  localparam logic [7:0] OffSramData   = 8'h10;
  localparam logic [7:0] OffFlashAddr  = 8'h20;
  localparam logic [7:0] OffFlashMaster= 8'h24;
  localparam logic [7:0] OffFlashAttr  = 8'h28;
  localparam logic [7:0] OffFlashData  = 8'h2C;

endpackage

// File: rtl/eccCaptureCtrl.sv
module eccCaptureCtrl
  import eccCapturePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sramSingle,
  input  logic       sramMulti,
  input  logic       flashSingle,
  input  logic       flashMulti,
  input  logic       regSel,
  input  logic       regWrite,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] cfgBits,
  output logic [7:0] statusBits,
  output logic       irq,
  output capStrobe_t strobe
);

  logic       cfgWr;
  logic       statusWr;
  logic [7:0] setVec;
  logic [7:0] clrVec;
  logic       sramHeld;
  logic       flashHeld;

  assign cfgWr    = regSel && regWrite && (regAddr == OffCfg);
  assign statusWr = regSel && regWrite && (regAddr == OffStatus);

  always_comb begin
    setVec = '0;
    setVec[BitSramSingle]  = sramSingle  && cfgBits[BitSramSingle];
    setVec[BitFlashSingle] = flashSingle && cfgBits[BitFlashSingle];
    setVec[BitSramMulti]   = sramMulti   && cfgBits[BitSramMulti];
    setVec[BitFlashMulti]  = flashMulti  && cfgBits[BitFlashMulti];
  end

  assign clrVec = statusWr ? (regWdata & FlagMask) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBits    <= '0;
      statusBits <= '0;
    end else begin
      if (cfgWr) cfgBits <= regWdata & FlagMask;
      statusBits <= (statusBits & ~clrVec) | setVec;
    end
  end

  assign sramHeld  = statusBits[BitSramSingle]  | statusBits[BitSramMulti];
  assign flashHeld = statusBits[BitFlashSingle] | statusBits[BitFlashMulti];

  assign strobe.loadSram  = (setVec[BitSramSingle]  | setVec[BitSramMulti])  & ~sramHeld;
  assign strobe.loadFlash = (setVec[BitFlashSingle] | setVec[BitFlashMulti]) & ~flashHeld;

  assign irq = |statusBits;

endmodule

// File: rtl/eccCaptureDatapath.sv
module eccCaptureDatapath
  import eccCapturePkg::*;
#(
  parameter int unsigned AddrW   = 32,
  parameter int unsigned DataW   = 32,
  parameter int unsigned AttrW   = 8,
  parameter int unsigned MasterW = 4,
  parameter int unsigned SynW    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  capStrobe_t         strobe,
  input  logic [AddrW-1:0]   sramAddr,
  input  logic [AttrW-1:0]   sramAttr,
  input  logic [DataW-1:0]   sramData,
  input  logic [MasterW-1:0] sramMaster,
  input  logic [SynW-1:0]    sramSyndrome,
  input  logic [AddrW-1:0]   flashAddr,
  input  logic [AttrW-1:0]   flashAttr,
  input  logic [DataW-1:0]   flashData,
  input  logic [MasterW-1:0] flashMaster,
  output logic [AddrW-1:0]   sramAddrQ,
  output logic [AttrW-1:0]   sramAttrQ,
  output logic [DataW-1:0]   sramDataQ,
  output logic [MasterW-1:0] sramMasterQ,
  output logic [SynW-1:0]    sramSynQ,
  output logic [AddrW-1:0]   flashAddrQ,
  output logic [AttrW-1:0]   flashAttrQ,
  output logic [DataW-1:0]   flashDataQ,
  output logic [MasterW-1:0] flashMasterQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramAddrQ   <= '0;
      sramAttrQ   <= '0;
      sramDataQ   <= '0;
      sramMasterQ <= '0;
      sramSynQ    <= '0;
    end else if (strobe.loadSram) begin
      sramAddrQ   <= sramAddr;
      sramAttrQ   <= sramAttr;
      sramDataQ   <= sramData;
      sramMasterQ <= sramMaster;
      sramSynQ    <= sramSyndrome;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flashAddrQ   <= '0;
      flashAttrQ   <= '0;
      flashDataQ   <= '0;
      flashMasterQ <= '0;
    end else if (strobe.loadFlash) begin
      flashAddrQ   <= flashAddr;
      flashAttrQ   <= flashAttr;
      flashDataQ   <= flashData;
      flashMasterQ <= flashMaster;
    end
  end

endmodule

// File: rtl/eccCapture.sv
module eccCapture
  import eccCapturePkg::*;
#(
  parameter int unsigned AddrW   = 32,
  parameter int unsigned DataW   = 32,
  parameter int unsigned AttrW   = 8,
  parameter int unsigned MasterW = 4,
  parameter int unsigned SynW    = 8,
  parameter int unsigned RdW     = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sramSingle,
  input  logic               sramMulti,
  input  logic [AddrW-1:0]   sramAddr,
  input  logic [AttrW-1:0]   sramAttr,
  input  logic [DataW-1:0]   sramData,
  input  logic [MasterW-1:0] sramMaster,
  input  logic [SynW-1:0]    sramSyndrome,
  output logic               sramErrResp,
  input  logic               flashSingle,
  input  logic               flashMulti,
  input  logic [AddrW-1:0]   flashAddr,
  input  logic [AttrW-1:0]   flashAttr,
  input  logic [DataW-1:0]   flashData,
  input  logic [MasterW-1:0] flashMaster,
  output logic               flashErrResp,
  input  logic               regSel,
  input  logic               regWrite,
  input  logic [7:0]         regAddr,
  input  logic [7:0]         regWdata,
  output logic [RdW-1:0]     regRdata,
  output logic               irq
);

  capStrobe_t         strobe;
  logic [7:0]         cfgBits;
  logic [7:0]         statusBits;
  logic [AddrW-1:0]   sramAddrCap;
  logic [AttrW-1:0]   sramAttrCap;
  logic [DataW-1:0]   sramDataCap;
  logic [MasterW-1:0] sramMasterCap;
  logic [SynW-1:0]    sramSynCap;
  logic [AddrW-1:0]   flashAddrCap;
  logic [AttrW-1:0]   flashAttrCap;
  logic [DataW-1:0]   flashDataCap;
  logic [MasterW-1:0] flashMasterCap;

  eccCaptureCtrl uCtrl (
    .clk, .rstN,
    .sramSingle, .sramMulti, .flashSingle, .flashMulti,
    .regSel, .regWrite, .regAddr, .regWdata,
    .cfgBits, .statusBits, .irq, .strobe
  );

  eccCaptureDatapath #(
    .AddrW(AddrW), .DataW(DataW), .AttrW(AttrW),
    .MasterW(MasterW), .SynW(SynW)
  ) uData (
    .clk, .rstN, .strobe,
    .sramAddr, .sramAttr, .sramData, .sramMaster, .sramSyndrome,
    .flashAddr, .flashAttr, .flashData, .flashMaster,
    .sramAddrQ(sramAddrCap), .sramAttrQ(sramAttrCap), .sramDataQ(sramDataCap),
    .sramMasterQ(sramMasterCap), .sramSynQ(sramSynCap),
    .flashAddrQ(flashAddrCap), .flashAttrQ(flashAttrCap),
    .flashDataQ(flashDataCap), .flashMasterQ(flashMasterCap)
  );

  assign sramErrResp  = sramMulti;
  assign flashErrResp = flashMulti;

  always_comb begin
    unique case (regAddr)
      OffCfg:         regRdata = RdW'(cfgBits);
      OffStatus:      regRdata = RdW'(statusBits);
      OffSramAddr:    regRdata = RdW'(sramAddrCap);
      OffSramSyn:     regRdata = RdW'(sramSynCap);
      OffSramMaster:  regRdata = RdW'(sramMasterCap);
      OffSramAttr:    regRdata = RdW'(sramAttrCap);
      OffSramData:    regRdata = RdW'(sramDataCap);
      OffFlashAddr:   regRdata = RdW'(flashAddrCap);
      OffFlashMaster: regRdata = RdW'(flashMasterCap);
      OffFlashAttr:   regRdata = RdW'(flashAttrCap);
      OffFlashData:   regRdata = RdW'(flashDataCap);
      default:        regRdata = '0;
    endcase
  end

endmodule

// File: rtl/eccCaptureChecker.sv
module eccCaptureChecker #(
  parameter int unsigned AddrW = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             sramSingle,
  input logic             sramMulti,
  input logic             flashSingle,
  input logic             flashMulti,
  input logic [7:0]       cfgBits,
  input logic [7:0]       statusBits,
  input logic             irq,
  input logic [AddrW-1:0] sramAddrCap,
  input logic [AddrW-1:0] flashAddrCap
);

  assert_sram_single_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sramSingle && cfgBits[5]) |=> statusBits[5]);

  assert_flash_single_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flashSingle && cfgBits[4]) |=> statusBits[4]);

  assert_sram_multi_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sramMulti && cfgBits[1]) |=> statusBits[1]);

  assert_flash_multi_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flashMulti && cfgBits[0]) |=> statusBits[0]);

  assert_disabled_no_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!statusBits[5] && !(sramSingle && cfgBits[5])) |=> !statusBits[5]);

  assert_event_raises_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((sramMulti && cfgBits[1]) || (flashSingle && cfgBits[4])) |=> irq);

  assert_sram_capture_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[5] || statusBits[1]) |=> $stable(sramAddrCap));

  assert_flash_capture_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[4] || statusBits[0]) |=> $stable(flashAddrCap));

endmodule

bind eccCapture eccCaptureChecker #(.AddrW(AddrW)) uChecker (
  .clk(clk), .rstN(rstN),
  .sramSingle(sramSingle), .sramMulti(sramMulti),
  .flashSingle(flashSingle), .flashMulti(flashMulti),
  .cfgBits(cfgBits), .statusBits(statusBits), .irq(irq),
  .sramAddrCap(sramAddrCap), .flashAddrCap(flashAddrCap)
);

// File: tb/eccCapture_test.sv
`timescale 1ns/1ps
module eccCapture_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sramSingle = 0, sramMulti = 0, flashSingle = 0, flashMulti = 0;
  logic [31:0] sramAddr = 0, sramData = 0, flashAddr = 0, flashData = 0;
  logic [7:0]  sramAttr = 0, sramSyndrome = 0, flashAttr = 0;
  logic [3:0]  sramMaster = 0, flashMaster = 0;
  logic        regSel = 0, regWrite = 0;
  logic [7:0]  regAddr = 0, regWdata = 0;
  logic [31:0] regRdata;
  logic        sramErrResp, flashErrResp, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] value;
    logic [7:0]  addr;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  eccCapture uut (
    .clk, .rstN,
    .sramSingle, .sramMulti, .sramAddr, .sramAttr, .sramData, .sramMaster,
    .sramSyndrome, .sramErrResp,
    .flashSingle, .flashMulti, .flashAddr, .flashAttr, .flashData,
    .flashMaster, .flashErrResp,
    .regSel, .regWrite, .regAddr, .regWdata, .regRdata, .irq
  );

  task automatic checkNow(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read against the scoreboard queue
  always @(posedge clk) begin
    if (regSel && !regWrite && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checkNow(regRdata, it.value, $sformatf("%s read 0x%0h", it.tag, it.addr));
    end
  end

  task automatic regWr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    regSel = 1; regWrite = 1; regAddr = a; regWdata = v;
    @(negedge clk);
    regSel = 0; regWrite = 0;
  endtask

  task automatic readExp(input logic [7:0] a, input logic [31:0] v, input string tag);
    expItem_t it;
    @(negedge clk);
    regSel = 1; regWrite = 0; regAddr = a;
    it.value = v; it.addr = a; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    regSel = 0;
  endtask

  task automatic sramEvt(input logic s, input logic m, input logic [31:0] a,
                         input logic [7:0] syn, input logic [3:0] mst,
                         input logic [7:0] at, input logic [31:0] d);
    @(negedge clk);
    sramSingle = s; sramMulti = m; sramAddr = a; sramSyndrome = syn;
    sramMaster = mst; sramAttr = at; sramData = d;
    #1 checkNow({31'b0, sramErrResp}, {31'b0, m}, "R11 sram error response");
    @(negedge clk);
    sramSingle = 0; sramMulti = 0;
  endtask

  task automatic flashEvt(input logic s, input logic m, input logic [31:0] a,
                          input logic [3:0] mst, input logic [7:0] at,
                          input logic [31:0] d);
    @(negedge clk);
    flashSingle = s; flashMulti = m; flashAddr = a;
    flashMaster = mst; flashAttr = at; flashData = d;
    #1 checkNow({31'b0, flashErrResp}, {31'b0, m}, "R11 flash error response");
    @(negedge clk);
    flashSingle = 0; flashMulti = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state
    checkNow({31'b0, irq}, 32'h0, "R7 irq after reset");
    readExp(8'h43, 32'h0, "R1 config reset");
    readExp(8'h42, 32'h0, "R7 status reset");
    readExp(8'h00, 32'h0, "R8 sram address capture reset");

    // reserved bits ignore writes
    regWr(8'h43, 8'hFF);
    readExp(8'h43, 32'h33, "R1 reserved bits read zero");

    // all disabled: no flag, irq or capture
    regWr(8'h43, 8'h00);
    sramEvt(1, 0, 32'hAAAA_0000, 8'h11, 4'h1, 8'h01, 32'h1);
    checkNow({31'b0, irq}, 32'h0, "R2 irq stays low when disabled");
    readExp(8'h42, 32'h0, "R2 no flag when disabled");
    readExp(8'h00, 32'h0, "R2 no capture when disabled");
    sramEvt(0, 1, 32'hBBBB_0000, 8'h22, 4'h2, 8'h02, 32'h2);
    readExp(8'h42, 32'h0, "R11 non-correctable disabled sets no flag");

    // SRAM single-bit enabled
    regWr(8'h43, 8'h20);
    sramEvt(1, 0, 32'h1000_0040, 8'h5A, 4'h3, 8'h21, 32'hDEAD_BEEF);
    checkNow({31'b0, irq}, 32'h1, "R3 irq raised");
    readExp(8'h42, 32'h20, "R3 sram single flag");
    readExp(8'h00, 32'h1000_0040, "R8 sram address");
    readExp(8'h04, 32'h5A, "R8 sram syndrome");
    readExp(8'h08, 32'h3, "R8 sram master");
    readExp(8'h0C, 32'h21, "R8 sram attributes");
    readExp(8'h10, 32'hDEAD_BEEF, "R8 sram data");

    // second event while held: no overwrite
    sramEvt(1, 0, 32'h2000_0000, 8'h77, 4'h7, 8'h77, 32'h7777_7777);
    readExp(8'h00, 32'h1000_0040, "R10 sram capture held");
    readExp(8'h10, 32'hDEAD_BEEF, "R10 sram data held");

    // clear by write-one
    regWr(8'h42, 8'h20);
    readExp(8'h42, 32'h0, "R7 write-one clear");
    checkNow({31'b0, irq}, 32'h0, "R7 irq drops after clear");

    // reload after clear
    sramEvt(1, 0, 32'h3000_0000, 8'h33, 4'h5, 8'h44, 32'h5555_0000);
    readExp(8'h00, 32'h3000_0000, "R10 sram capture reloads");
    regWr(8'h42, 8'h20);

    // flash non-correctable
    regWr(8'h43, 8'h33);
    flashEvt(0, 1, 32'h0008_1000, 4'h2, 8'h11, 32'h1234_5678);
    readExp(8'h42, 32'h01, "R6 flash non-correctable flag");
    readExp(8'h20, 32'h0008_1000, "R9 flash address");
    readExp(8'h24, 32'h2, "R9 flash master");
    readExp(8'h28, 32'h11, "R9 flash attributes");
    readExp(8'h2C, 32'h1234_5678, "R9 flash data");

    // flash single-bit, capture held
    flashEvt(1, 0, 32'h0009_0000, 4'h9, 8'h99, 32'h9);
    readExp(8'h42, 32'h11, "R4 flash single flag");
    readExp(8'h20, 32'h0008_1000, "R10 flash capture held");

    // partial clear
    regWr(8'h42, 8'h01);
    readExp(8'h42, 32'h10, "R7 clear only written bit");
    checkNow({31'b0, irq}, 32'h1, "R7 irq stays with flag left");
    regWr(8'h42, 8'h10);

    // simultaneous single and multi on SRAM
    sramEvt(1, 1, 32'h4444_0000, 8'hC3, 4'hA, 8'h5C, 32'hCAFE_F00D);
    readExp(8'h42, 32'h22, "R12 both sram flags R5");
    readExp(8'h00, 32'h4444_0000, "R12 single capture");
    readExp(8'h04, 32'hC3, "R12 syndrome capture");

    // set wins over simultaneous clear
    @(negedge clk);
    regSel = 1; regWrite = 1; regAddr = 8'h42; regWdata = 8'h20;
    sramSingle = 1;
    @(negedge clk);
    regSel = 0; regWrite = 0; sramSingle = 0;
    readExp(8'h42, 32'h22, "R12 set beats clear");
    regWr(8'h42, 8'h22);
    checkNow({31'b0, irq}, 32'h0, "R7 irq low when all clear");

    repeat (3) @(negedge clk);
    checkNow(expQ.size(), 32'h0, "scoreboard drained");
    finishRun();
  end

endmodule